// File: doc/BRIEF.md
# Dual-Lane Q15 Rounding Multiplier

This execution unit multiplies packed pairs of signed Q15 fractions. Each 32-bit source operand carries two halfword lanes: bits 31..16 form the upper lane and bits 15..0 form the lower lane. Each lane of the first source is multiplied by the matching lane of the second source. The lane multiplies its two inputs into a full signed product and doubles that product to a Q31 value. It then adds one half of a Q15 least significant bit and keeps the top halfword. The two lane results are packed into one 32-bit result, with the upper lane in bits 31..16.

Only one input pair can overflow: both inputs equal to -1.0 (0x8000). For that pair the lane output is clamped to 0x7FFF and the rounding path is skipped. Any clamp during an executed operation sets a sticky overflow bit at bit 21 of a 32-bit control register that the block holds. Software can write that register through a write port.

The block decodes the instruction word and acts only on its own encoding. For a matching instruction it reports:
- the decode match,
- the destination index,
- a write-enable,
- a pulse telling the surrounding logic that the base accumulator pair is now undefined.

The `PIPE_OUT` parameter selects how the result is delivered. With the default, the result is registered one cycle after issue. Otherwise it is presented in the same cycle.

Top module: `q15_pair_mul`

## Requirements
- R1: The upper result halfword (bits 31..16) equals bits 31..16 of (2·(rs[31:16]·rt[31:16]) + 0x8000), with the product taken as signed 16×16 bits.
- R2: The lower result halfword (bits 15..0) is formed from rs[15:0] and rt[15:0] by the same formula, independently of the upper lane.
- R3: A lane whose two inputs are both 0x8000 outputs 0x7FFF, whatever the other lane does.
- R4: When an executed matching instruction clamps either lane, control-register bit 21 becomes 1. It stays 1 through later non-clamping operations.
- R5: The control register resets to all zeros. A software write loads all 32 bits from the write data, which is how bit 21 is cleared.
- R6: An instruction matches only when bits 31..26 = 6'b001000, bits 9..3 = 7'b0100010 and bits 2..0 = 3'b101. Bit 10 and the two source index fields (bits 25..21 and 20..16) do not affect the match.
- R7: The destination index output equals instruction bits 15..11.
- R8: The write-enable and the base-accumulator-clobbered pulse are 1 exactly for an issued matching instruction, and 0 otherwise.
- R9: With `PIPE_OUT`=1, the result, index, match, write-enable and clobber outputs appear on the clock edge that follows the issue cycle. The bit-21 update lands on that same edge.
- R10: An issued non-matching instruction leaves bit 21 unchanged, even when both operands are 0x8000 in either lane.
- R11: If a software write and a clamp occur on the same edge, bit 21 ends at 1 and the other bits take the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| insn_i | input | 32 | Instruction word |
| rs_i | input | 32 | First packed Q15 source |
| rt_i | input | 32 | Second packed Q15 source |
| sw_we_i | input | 1 | Software write strobe for the control register |
| sw_wdata_i | input | 32 | Software write data |
| result_o | output | 32 | Packed rounded Q15 result |
| rd_o | output | 5 | Destination register index |
| match_o | output | 1 | Instruction word decodes to this operation |
| wr_en_o | output | 1 | Destination write-enable |
| acc0_clobber_o | output | 1 | Base accumulator pair is now undefined |
| ctl_o | output | 32 | Control register contents |

## Verification
On every cycle the assertions check the following:
- the write-enable implies a decode match;
- the clobber pulse tracks the write-enable;
- a clamped lane in the previous cycle yields 0x7FFF;
- a clamp sets bit 21, and the bit then holds without a software write;
- software writes land.

Only the bench's scenarios can show some properties. These are the rounding arithmetic over random operands, lane independence, the carry of the rounding add into bit 16, and the rejection of corrupted encodings. The same holds for the same-edge priority of a clamp over a software clear.

// File: rtl/q15_pair_pkg.sv
package q15_pair_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 16;
  localparam int unsigned N_LANES = WORD_W / LANE_W;
  localparam int unsigned IDX_W = 5;
  localparam int unsigned OVF_BIT = 21;

  localparam logic [5:0] MAJOR_OP = 6'b001000;
  localparam logic [6:0] FUNC_OP  = 7'b0100010;
  localparam logic [2:0] TAIL_OP  = 3'b101;

  localparam logic [LANE_W-1:0] Q15_NEG_ONE = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] Q15_MAX_POS = {1'b0, {(LANE_W-1){1'b1}}};

  typedef struct packed {
    logic [5:0]       major;
    logic [IDX_W-1:0] src_t;
    logic [IDX_W-1:0] src_s;
    logic [IDX_W-1:0] dst;
    logic             spare;
    logic [6:0]       func;
    logic [2:0]       tail;
  } insn_t;
endpackage

// File: rtl/q15_insn_decode.sv
module q15_insn_decode
  import q15_pair_pkg::*;
(
  input  logic [WORD_W-1:0] insn_i,
  output logic              match_o,
  output logic [IDX_W-1:0]  rd_o
);
  insn_t f;
  logic  unused_fields;

  assign f = insn_t'(insn_i);
  assign unused_fields = ^{f.src_t, f.src_s, f.spare};

  always_comb begin
    match_o = (f.major == MAJOR_OP) && (f.func == FUNC_OP) && (f.tail == TAIL_OP);
    rd_o    = f.dst;
  end
endmodule

// File: rtl/q15_lane_mul.sv
module q15_lane_mul
  import q15_pair_pkg::*;
(
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] y_o,
  output logic              clamp_o
);
  localparam int unsigned PROD_W = 2 * LANE_W;
  localparam logic [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (LANE_W - 1);

  logic signed [PROD_W-1:0] prod;
  logic        [PROD_W-1:0] rounded;
  logic                     unused_low;

  always_comb begin
    prod    = PROD_W'($signed(a_i)) * PROD_W'($signed(b_i));
    rounded = {prod[PROD_W-2:0], 1'b0} + HALF_LSB;
    clamp_o = (a_i == Q15_NEG_ONE) && (b_i == Q15_NEG_ONE);
    y_o     = clamp_o ? Q15_MAX_POS : rounded[PROD_W-1:LANE_W];
  end

  assign unused_low = ^{rounded[LANE_W-1:0], prod[PROD_W-1]};
endmodule

// File: rtl/q15_ovf_ctl.sv
module q15_ovf_ctl
  import q15_pair_pkg::*;
#(
  parameter int unsigned CTL_W = WORD_W,
  parameter int unsigned FLAG_POS = OVF_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             sw_we_i,
  input  logic [CTL_W-1:0] sw_wdata_i,
  output logic [CTL_W-1:0] ctl_o
);
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_d;
  logic             ctl_en;

  always_comb begin
    ctl_en = sw_we_i | set_i;
    ctl_d  = sw_we_i ? sw_wdata_i : ctl_q;
    if (set_i) ctl_d[FLAG_POS] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ctl_q[FLAG_POS]);
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[FLAG_POS] && !sw_we_i) |=> ctl_q[FLAG_POS]);
  assert_sw_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we_i && !set_i) |=> (ctl_q == $past(sw_wdata_i)));
endmodule

// File: rtl/q15_pair_mul.sv
module q15_pair_mul
  import q15_pair_pkg::*;
#(
  parameter bit PIPE_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [WORD_W-1:0] insn_i,
  input  logic [WORD_W-1:0] rs_i,
  input  logic [WORD_W-1:0] rt_i,
  input  logic              sw_we_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic [WORD_W-1:0] result_o,
  output logic [IDX_W-1:0]  rd_o,
  output logic              match_o,
  output logic              wr_en_o,
  output logic              acc0_clobber_o,
  output logic [WORD_W-1:0] ctl_o
);
  logic [WORD_W-1:0]  res_c;
  logic [N_LANES-1:0] clamp_c;
  logic               hit_c;
  logic [IDX_W-1:0]   rd_c;
  logic               fire_c;

  q15_insn_decode u_dec (
    .insn_i  (insn_i),
    .match_o (hit_c),
    .rd_o    (rd_c)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    q15_lane_mul u_lane (
      .a_i     (rs_i[g*LANE_W +: LANE_W]),
      .b_i     (rt_i[g*LANE_W +: LANE_W]),
      .y_o     (res_c[g*LANE_W +: LANE_W]),
      .clamp_o (clamp_c[g])
    );
  end

  assign fire_c = issue_i & hit_c;

  q15_ovf_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (fire_c & (|clamp_c)),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .ctl_o      (ctl_o)
  );

  if (PIPE_OUT) begin : g_pipe
    logic [WORD_W-1:0] res_q;
    logic [IDX_W-1:0]  rd_q;
    logic              hit_q;
    logic              fire_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        rd_q  <= '0;
      end else if (issue_i) begin
        res_q <= res_c;
        rd_q  <= rd_c;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q  <= 1'b0;
        fire_q <= 1'b0;
      end else begin
        hit_q  <= hit_c;
        fire_q <= fire_c;
      end
    end

    assign result_o       = res_q;
    assign rd_o           = rd_q;
    assign match_o        = hit_q;
    assign wr_en_o        = fire_q;
    assign acc0_clobber_o = fire_q;

    assert_clamp_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && rs_i[31:16] == Q15_NEG_ONE && rt_i[31:16] == Q15_NEG_ONE)
        |=> (result_o[31:16] == Q15_MAX_POS));
    assert_clamp_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && rs_i[15:0] == Q15_NEG_ONE && rt_i[15:0] == Q15_NEG_ONE)
        |=> (result_o[15:0] == Q15_MAX_POS));
    assert_issue_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> $past(issue_i));
    assert_flag_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o && (result_o[31:16] == Q15_MAX_POS) && $past(rs_i[31:16] == Q15_NEG_ONE)
        && $past(rt_i[31:16] == Q15_NEG_ONE) |-> ctl_o[OVF_BIT]);
  end else begin : g_comb
    assign result_o       = res_c;
    assign rd_o           = rd_c;
    assign match_o        = hit_c;
    assign wr_en_o        = fire_c;
    assign acc0_clobber_o = fire_c;
  end

  assert_wren_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> match_o);
  assert_clobber_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc0_clobber_o == wr_en_o);
endmodule

// File: tb/q15_pair_mul_bench.sv
module q15_pair_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [31:0] insn_i, rs_i, rt_i, sw_wdata_i;
  logic        sw_we_i;
  logic [31:0] result_o, ctl_o;
  logic [4:0]  rd_o;
  logic        match_o, wr_en_o, acc0_clobber_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [31:0] exp_ctl;
  bit          timed_out = 1'b0;

  always #4 clk = ~clk;

  q15_pair_mul u_q15_pair_mul (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_i(insn_i),
    .rs_i(rs_i), .rt_i(rt_i), .sw_we_i(sw_we_i), .sw_wdata_i(sw_wdata_i),
    .result_o(result_o), .rd_o(rd_o), .match_o(match_o), .wr_en_o(wr_en_o),
    .acc0_clobber_o(acc0_clobber_o), .ctl_o(ctl_o)
  );

  function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b);
    longint p;
    if (a == 16'h8000 && b == 16'h8000) return 16'h7FFF;
    p = longint'($signed(a)) * longint'($signed(b));
    p = p * 2 + 32768;
    return p[31:16];
  endfunction

  function automatic logic [31:0] make_insn(input logic [4:0] t, input logic [4:0] s,
                                            input logic [4:0] d, input logic x);
    return {6'b001000, t, s, d, x, 7'b0100010, 3'b101};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input logic sw, input logic [31:0] swd);
    logic hit;
    logic clamp;
    hit   = (ins[31:26] == 6'b001000) && (ins[9:3] == 7'b0100010) && (ins[2:0] == 3'b101);
    clamp = (a[31:16] == 16'h8000 && b[31:16] == 16'h8000) ||
            (a[15:0] == 16'h8000 && b[15:0] == 16'h8000);
    @(negedge clk);
    issue_i = 1'b1; insn_i = ins; rs_i = a; rt_i = b; sw_we_i = sw; sw_wdata_i = swd;
    if (sw) exp_ctl = swd;
    if (hit && clamp) exp_ctl[21] = 1'b1;
    @(negedge clk);
    issue_i = 1'b0; sw_we_i = 1'b0;
    check("R6 match", {31'd0, match_o}, {31'd0, hit});
    check("R8 wr_en", {31'd0, wr_en_o}, {31'd0, hit});
    check("R8 clobber", {31'd0, acc0_clobber_o}, {31'd0, hit});
    check(hit ? "R4 flag" : "R10 flag", ctl_o, exp_ctl);
    if (hit) begin
      check("R1 R9 upper", {16'd0, result_o[31:16]}, {16'd0, ref_lane(a[31:16], b[31:16])});
      check("R2 lower", {16'd0, result_o[15:0]}, {16'd0, ref_lane(a[15:0], b[15:0])});
      check("R7 rd", {27'd0, rd_o}, {27'd0, ins[15:11]});
    end
  endtask

  task automatic sw_write(input logic [31:0] d);
    @(negedge clk);
    sw_we_i = 1'b1; sw_wdata_i = d; exp_ctl = d;
    @(negedge clk);
    sw_we_i = 1'b0;
    check("R5 sw write", ctl_o, exp_ctl);
  endtask

  task automatic run_all();
    logic [31:0] ins, a, b;
    rst_n = 1'b0; issue_i = 1'b0; insn_i = '0; rs_i = '0; rt_i = '0;
    sw_we_i = 1'b0; sw_wdata_i = '0; exp_ctl = '0;
    repeat (3) @(negedge clk);
    check("R5 reset ctl", ctl_o, 32'd0);
    check("R8 reset wr_en", {31'd0, wr_en_o}, 32'd0);
    rst_n = 1'b1;

    // R1 R2: rounding carry into bit 16 in each lane independently
    run_op(make_insn(5'd1, 5'd2, 5'd3, 1'b0), 32'h0001_1234, 32'h4000_0100, 1'b0, '0);
    check("R1 carry", {16'd0, result_o[31:16]}, 32'h0000_0001);
    run_op(make_insn(5'd1, 5'd2, 5'd4, 1'b1), 32'h1234_0001, 32'h0100_4000, 1'b0, '0);
    check("R2 carry", {16'd0, result_o[15:0]}, 32'h0000_0001);
    check("R4 no clamp keeps 0", ctl_o, 32'd0);
    // R1 R2: 0x8000 x 0x7FFF and 0x7FFF x 0x7FFF in both lanes
    run_op(make_insn(5'd5, 5'd6, 5'd7, 1'b0), 32'h8000_7FFF, 32'h7FFF_7FFF, 1'b0, '0);
    check("R1 neg edge", {16'd0, result_o[31:16]}, 32'h0000_8001);
    check("R2 max", {16'd0, result_o[15:0]}, 32'h0000_7FFE);
    run_op(make_insn(5'd5, 5'd6, 5'd8, 1'b0), 32'h7FFF_8000, 32'h7FFF_7FFF, 1'b0, '0);
    check("R1 max", {16'd0, result_o[31:16]}, 32'h0000_7FFE);
    check("R2 neg edge", {16'd0, result_o[15:0]}, 32'h0000_8001);
    // R10: non-matching instruction with clamp operands
    run_op(32'h2000_0000, 32'h8000_8000, 32'h8000_8000, 1'b0, '0);
    check("R10 no flag", ctl_o, 32'd0);
    // R3 R4: clamp upper lane only, then lower lane only
    run_op(make_insn(5'd9, 5'd9, 5'd9, 1'b0), 32'h8000_2000, 32'h8000_C000, 1'b0, '0);
    check("R3 upper clamp", {16'd0, result_o[31:16]}, 32'h0000_7FFF);
    check("R4 flag set", {31'd0, ctl_o[21]}, 32'd1);
    run_op(make_insn(5'd9, 5'd9, 5'd10, 1'b0), 32'h1000_1000, 32'h1000_1000, 1'b0, '0);
    check("R4 sticky", {31'd0, ctl_o[21]}, 32'd1);
    sw_write(32'h0000_00A5);
    run_op(make_insn(5'd9, 5'd9, 5'd11, 1'b1), 32'h3000_8000, 32'hF000_8000, 1'b0, '0);
    check("R3 lower clamp", {16'd0, result_o[15:0]}, 32'h0000_7FFF);
    // R11: clamp and software clear on the same edge
    run_op(make_insn(5'd2, 5'd3, 5'd12, 1'b0), 32'h8000_8000, 32'h8000_8000, 1'b1, 32'h0000_0F00);
    check("R11 set wins", ctl_o, 32'h0020_0F00);
    sw_write(32'h0);

    // Random mix with fixed seed
    void'($urandom(32'h0000_5EED));
    for (int i = 0; i < 400; i++) begin
      ins = make_insn(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom));
      case ($urandom % 8)
        0: ins[31:26] = ins[31:26] ^ 6'(1 << ($urandom % 6));
        1: ins[9:3]   = ins[9:3] ^ 7'(1 << ($urandom % 7));
        2: ins[2:0]   = ins[2:0] ^ 3'(1 << ($urandom % 3));
        default: ;
      endcase
      a = $urandom; b = $urandom;
      if ($urandom % 6 == 0) begin a[31:16] = 16'h8000; b[31:16] = 16'h8000; end
      if ($urandom % 6 == 0) begin a[15:0] = 16'h8000; b[15:0] = 16'h8000; end
      run_op(ins, a, b, ($urandom % 20) == 0, $urandom);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule